// File: doc/BRIEF.md
# Stereo PDM Microphone Receiver with Wake-Up Gating

This block sits on the host side of one or two pulse-density-modulated microphones that share a single data wire. It divides the system clock down to a bit clock for the microphones. It samples the shared wire once in every half-period of that bit clock. The samples are split into a right and a left 1-bit stream, and each stream has its own one-cycle valid strobe. The half-period length in system clocks is a run-time input.

Dropping the run enable stops the bit clock at a low level, which sends the microphones to sleep. After the clock is started again, or after its ratio is changed, the microphones need a fixed number of bit-clock cycles before their data means anything. The block counts those cycles, raises a ready flag when the count is complete, and emits no valid strobe until then.

The output streams carry valid strobes but have no ready input. The microphones cannot be paused, so the consumer must take each bit in the cycle its strobe is high. A strobe that is missed is lost. Per-channel enables suppress the strobes of a channel that is not fitted, as in a mono board.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While reset is asserted and right after it is released with the run enable low, the bit clock is low, ready is low and both valid strobes are low.
- R2: While running, the bit clock is high for exactly H system cycles and low for exactly H system cycles, where H is the half-period input. A value of 0 is treated as H = 1.
- R3: The right bit is the data-wire value in the last system cycle of the low half. That cycle is just before the rising edge. The bit appears with a one-cycle right valid in the cycle after the rising edge.
- R4: The left bit is the data-wire value in the last system cycle of the high half. That cycle is just before the falling edge. The bit appears with a one-cycle left valid in the cycle after the falling edge.
- R5: After a restart, ready rises in the same cycle as the WAKE_CYCLES-th rising edge of the bit clock. No valid strobe appears before that. The first strobe after ready is the left bit of the high half that starts at that edge.
- R6: A restart occurs when the run enable rises or the half-period input changes while running. On a restart, ready falls in the next cycle, the bit clock restarts with a full low half, and the wake-up count begins again from zero.
- R7: With the run enable low, the bit clock is held low from the next cycle on, ready is low, and no valid strobe is produced.
- R8: When a channel's enable is low, that channel emits no valid strobes. The other channel is not affected.
- R9: Each valid strobe is exactly one system cycle wide. The two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Run enable for the bit clock; low puts the microphones to sleep |
| half_div | input | DIV_W | Bit-clock half-period in system cycles (0 acts as 1) |
| left_en | input | 1 | Enable for the left-channel stream |
| right_en | input | 1 | Enable for the right-channel stream |
| pdm_data | input | 1 | Shared microphone data wire |
| pdm_clk | output | 1 | Bit clock to the microphones |
| ready | output | 1 | High once the wake-up interval has elapsed |
| left_bit | output | 1 | Left-channel sample |
| left_valid | output | 1 | One-cycle strobe for left_bit |
| right_bit | output | 1 | Right-channel sample |
| right_valid | output | 1 | One-cycle strobe for right_bit |

## Verification
Some properties are checked on every cycle:
- each right strobe lands just after a rising edge of the bit clock, and each left strobe just after a falling edge;
- no strobe appears while ready was low;
- strobes are single-cycle and never overlap;
- disabling the clock forces the clock and ready low;
- a ratio change clears ready.

Other behaviour only the bench scenarios can show:
- the exact half-period length for each ratio, including the zero case;
- ready arriving together with exactly the counted rising edge;
- the captured bit values matching what each simulated microphone drove in its half;
- the exact number of strobes per channel under each enable pattern.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

  // Level of the bit clock during the half-period that a channel owns.
  // The low half follows a falling edge (right), the high half follows a
  // rising edge (left).
  typedef enum logic {
    PH_RIGHT = 1'b0,
    PH_LEFT  = 1'b1
  } half_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/pdm_bitclk_gen.sv
module pdm_bitclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             bit_clk,
  output logic             restart,
  output logic             half_end
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last_idx;
  logic             en_q;

  // Zero behaves as a one-cycle half-period.
  always_comb begin
    if (div_q == '0) last_idx = '0;
    else             last_idx = div_q - DIV_W'(1);
  end

  // New ratio or fresh enable: start over from the low half.
  assign restart  = run && (!en_q || (half_div != div_q));
  // Last system cycle of the current half-period.
  assign half_end = run && !restart && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_q   <= '0;
      en_q    <= 1'b0;
      bit_clk <= 1'b0;
    end else begin
      en_q  <= run;
      div_q <= half_div;
      if (!run || restart) begin
        cnt_q   <= '0;
        bit_clk <= 1'b0;
      end else if (half_end) begin
        cnt_q   <= '0;
        bit_clk <= ~bit_clk;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/pdm_wake_timer.sv
module pdm_wake_timer #(
  parameter int WAKE_CYCLES = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic rise_tick,
  output logic ready
);

  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(WAKE_CYCLES);

  logic [CNT_W-1:0] count_q;

  assign ready = (count_q == DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!run || restart) begin
      count_q <= '0;
    end else if (rise_tick && !ready) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pdm_chan_capture.sv
module pdm_chan_capture
  import pdm_rx_pkg::*;
#(
  parameter half_e SIDE = PH_RIGHT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_end,
  input  logic bit_clk,
  input  logic ready,
  input  logic ch_en,
  input  logic pdm_data,
  output logic bit_q,
  output logic valid_q
);

  logic take;

  // Sample in the final cycle of the half this channel owns, i.e. as late
  // as possible after the microphone's driver turned on.
  assign take = half_end && (bit_clk == logic'(SIDE)) && ready && ch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) bit_q <= pdm_data;
    end
  end

endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
  import pdm_rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int WAKE_CYCLES = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] half_div,
  input  logic             left_en,
  input  logic             right_en,
  input  logic             pdm_data,
  output logic             pdm_clk,
  output logic             ready,
  output logic             left_bit,
  output logic             left_valid,
  output logic             right_bit,
  output logic             right_valid
);

  logic              restart;
  logic              half_end;
  logic              rise_tick;
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] ch_bit;
  logic [NUM_CH-1:0] ch_valid;

  pdm_bitclk_gen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (clk_en),
    .half_div (half_div),
    .bit_clk  (pdm_clk),
    .restart  (restart),
    .half_end (half_end)
  );

  // End of a low half is the cycle before a rising edge.
  assign rise_tick = half_end && !pdm_clk;

  pdm_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (clk_en),
    .restart   (restart),
    .rise_tick (rise_tick),
    .ready     (ready)
  );

  assign ch_en[PH_RIGHT] = right_en;
  assign ch_en[PH_LEFT]  = left_en;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pdm_chan_capture #(.SIDE(half_e'(g))) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_end (half_end),
      .bit_clk  (pdm_clk),
      .ready    (ready),
      .ch_en    (ch_en[g]),
      .pdm_data (pdm_data),
      .bit_q    (ch_bit[g]),
      .valid_q  (ch_valid[g])
    );
  end

  assign right_bit   = ch_bit[PH_RIGHT];
  assign right_valid = ch_valid[PH_RIGHT];
  assign left_bit    = ch_bit[PH_LEFT];
  assign left_valid  = ch_valid[PH_LEFT];

endmodule

// File: rtl/pdm_stereo_rx_chk.sv
module pdm_stereo_rx_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic [DIV_W-1:0] half_div,
  input logic             pdm_clk,
  input logic             ready,
  input logic             left_valid,
  input logic             right_valid
);

  AST_RIGHT_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |-> (pdm_clk && !$past(pdm_clk))); // R3

  AST_LEFT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |-> (!pdm_clk && $past(pdm_clk))); // R4

  AST_NO_VALID_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid) |-> $past(ready)); // R5

  AST_RATIO_CHANGE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && (half_div != $past(half_div))) |=> !ready); // R6

  AST_CLK_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (!pdm_clk && !ready)); // R7

  AST_LEFT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |=> !left_valid); // R9

  AST_RIGHT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |=> !right_valid); // R9

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_valid && right_valid)); // R9

endmodule

bind pdm_stereo_rx pdm_stereo_rx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en      (clk_en),
  .half_div    (half_div),
  .pdm_clk     (pdm_clk),
  .ready       (ready),
  .left_valid  (left_valid),
  .right_valid (right_valid)
);

// File: tb/pdm_stereo_rx_test.sv
module pdm_stereo_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int WAKE       = 8;
  localparam int K          = 10;
  localparam int NVEC       = 5;
  // {half_div[7:0], left_en, right_en}
  localparam logic [9:0] VEC [NVEC] = '{
    {8'd3, 1'b1, 1'b1},
    {8'd0, 1'b1, 1'b1},
    {8'd5, 1'b1, 1'b0},
    {8'd2, 1'b0, 1'b1},
    {8'd4, 1'b0, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clk_en = 1'b0;
  logic [DIV_W-1:0] half_div = '0;
  logic             left_en = 1'b0;
  logic             right_en = 1'b0;
  logic             pdm_data;
  logic             pdm_clk, ready, left_bit, left_valid, right_bit, right_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int rise_total = 0;
  int fall_total = 0;
  int base = 0;
  int win_l = 0;
  int win_r = 0;
  int tot_valid = 0;
  logic prev_l = 1'b0;
  logic prev_r = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic pat_l(int n);
    return n[0] ^ n[2];
  endfunction

  function automatic logic pat_r(int n);
    return ~(n[1] ^ n[3]);
  endfunction

  // Two microphone models: left drives in the high half, right in the low half.
  always @(posedge pdm_clk) rise_total <= rise_total + 1;
  always @(negedge pdm_clk) fall_total <= fall_total + 1;
  assign pdm_data = pdm_clk ? pat_l(rise_total) : pat_r(fall_total);

  pdm_stereo_rx #(.DIV_W(DIV_W), .WAKE_CYCLES(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .half_div(half_div),
    .left_en(left_en), .right_en(right_en), .pdm_data(pdm_data),
    .pdm_clk(pdm_clk), .ready(ready), .left_bit(left_bit),
    .left_valid(left_valid), .right_bit(right_bit), .right_valid(right_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Stream monitor: data values, window counts, strobe shape.
  always @(negedge clk) begin
    int d;
    if (rst_n && !done) begin
      d = rise_total - base;
      if (left_valid) begin
        tot_valid++;
        check(left_bit == pat_l(rise_total) && d >= WAKE, "R4",
              "left bit / timing", int'(left_bit), int'(pat_l(rise_total)));
        check(!right_valid && !prev_l, "R9", "left strobe shape", 1, 0);
        if (d >= WAKE && d < WAKE + K) win_l++;
      end
      if (right_valid) begin
        tot_valid++;
        check(right_bit == pat_r(fall_total) && d > WAKE, "R3",
              "right bit / timing", int'(right_bit), int'(pat_r(fall_total)));
        check(!prev_r, "R9", "right strobe shape", 1, 0);
        if (d > WAKE && d <= WAKE + K) win_r++;
      end
      prev_l = left_valid;
      prev_r = right_valid;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ready_check(input string req);
    while (!ready) step();
    check(rise_total - base == WAKE, req, "rising edges at ready",
          rise_total - base, WAKE);
  endtask

  task automatic measure_runs(input int heff);
    int hi;
    int lo;
    hi = 0;
    lo = 0;
    while (pdm_clk) step();
    while (!pdm_clk) step();
    while (pdm_clk) begin hi++; step(); end
    while (!pdm_clk) begin lo++; step(); end
    check(hi == heff, "R2", "high half length", hi, heff);
    check(lo == heff, "R2", "low half length", lo, heff);
  endtask

  task automatic run_vec(input logic [9:0] v);
    int h;
    h = int'(v[9:2]);
    step();
    half_div = v[9:2];
    left_en  = v[1];
    right_en = v[0];
    clk_en   = 1'b1;
    base  = rise_total;
    win_l = 0;
    win_r = 0;
    step();
    check(!ready, "R6", "ready after restart", int'(ready), 0);
    wait_ready_check("R5");
    measure_runs((h == 0) ? 1 : h);
    while (rise_total - base < WAKE + K + 2) step();
    check(win_l == (v[1] ? K : 0), "R8", "left strobes in window", win_l, v[1] ? K : 0);
    check(win_r == (v[0] ? K : 0), "R8", "right strobes in window", win_r, v[0] ? K : 0);
  endtask

  initial begin
    int tv;
    // R1: reset state
    repeat (3) step();
    check(!pdm_clk && !ready && !left_valid && !right_valid, "R1", "outputs in reset",
          int'({pdm_clk, ready, left_valid, right_valid}), 0);
    rst_n = 1'b1;
    half_div = 8'd3;
    step();
    check(!pdm_clk && !ready && !left_valid && !right_valid, "R1", "outputs after reset",
          int'({pdm_clk, ready, left_valid, right_valid}), 0);

    // R7: idle clock stays low, no strobes
    left_en = 1'b1;
    right_en = 1'b1;
    tv = tot_valid;
    for (int i = 0; i < 40; i++) begin
      if (pdm_clk || ready) check(0, "R7", "bit clock while off", int'(pdm_clk), 0);
      step();
    end
    check(tot_valid == tv, "R7", "strobes while off", tot_valid - tv, 0);

    // Vector table
    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R6: ratio change mid-run restarts the wake count
    left_en = 1'b1;
    right_en = 1'b1;
    half_div = 8'd2;
    base = rise_total;
    step();
    wait_ready_check("R6");
    half_div = 8'd3;
    base = rise_total;
    step();
    check(!ready && !pdm_clk, "R6", "ready/clock after ratio change",
          int'({ready, pdm_clk}), 0);
    wait_ready_check("R6");

    // R7: stopping the clock drops ready and holds clock low
    clk_en = 1'b0;
    step();
    check(!ready && !pdm_clk, "R7", "ready/clock after stop", int'({ready, pdm_clk}), 0);
    tv = tot_valid;
    repeat (30) step();
    check(tot_valid == tv && !pdm_clk, "R7", "strobes while stopped", tot_valid - tv, 0);

    // R6: re-enable restarts the full wake interval
    clk_en = 1'b1;
    base = rise_total;
    step();
    check(!ready, "R6", "ready right after re-enable", int'(ready), 0);
    wait_ready_check("R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule